// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash Walk

This block keeps the in-flight instructions of several hardware threads in program order. The front end allocates an entry with a thread number, a sequence number and a small tag. Execution reports completion by thread and sequence number. Each thread sees its own oldest entry, whether that entry may commit, and a retire strobe to remove it. A squash names a thread and a sequence number. The block then walks backward from that thread's youngest entry and marks every entry younger than the given number. It marks a fixed number of entries per cycle and frees the marked entries from the tail in the cycle the walk ends.

The total capacity is shared between threads under a sharing rule fixed at build time. Under the dynamic rule any thread may use the whole buffer. Under the partitioned rule the capacity is divided evenly among the threads that are active. Under the threshold rule each thread is capped at a set percentage of the capacity. An inactive thread gets no allowance. Allocations the block cannot take are dropped and flagged. Status outputs give the free count, full, empty, per-thread allowance left, per-thread state and squash completion.

Top module: `rob_mt`

## Requirements
- R1: After reset every thread is idle (state code 0), `empty`=1, `full`=0, `free_total` equals the capacity, no head is valid, all `sq_done` bits and `all_sq_done` are 1, and `alloc_err` and `can_commit` are 0.
- R2: An accepted allocation appends to its thread in order. One cycle later the head shows the oldest sequence number of that thread, and `free_total` has dropped by one.
- R3: A completion for (thread, sequence) marks that live entry ready. `head_ready` of the thread and `can_commit` (any active thread with a ready head) follow one cycle later. Completing a non-head entry leaves `head_ready` low.
- R4: A retire strobe removes the head only if it is ready. A strobe on a head that is not ready has no effect on the head or on the counts.
- R5: A squash puts the thread in state 2 and drops its `sq_done` bit (and `all_sq_done`) after the request edge. The walk marks up to `SQ_W` entries per cycle, starting at the youngest. With K younger entries and an older entry still present, `sq_done` returns high K/`SQ_W` (rounded down) + 1 edges after the request edge.
- R6: While a walk runs, occupancy does not change. On the finishing edge the squashed entries leave from the tail, and the head remains the oldest surviving entry.
- R7: A squashing thread rejects allocations (with `alloc_err`) and keeps `head_ready` low. Other threads keep completing and committing.
- R8: Under the partitioned rule each active thread's allowance is capacity / active-thread count and an inactive thread's allowance is 0. A change of `active_mask` takes effect one edge later.
- R9: An allocation for a thread at its allowance, or while the buffer is full, is dropped and `alloc_err` is 1 for the cycle after.
- R10: `full` is 1 exactly when total occupancy equals the capacity, `empty` is 1 exactly when it is 0, and `free_total` is capacity minus occupancy.
- R11: "Younger" is decided by wrap-safe modular difference of sequence numbers, so numbers that wrapped past zero count as younger than numbers just below the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_mask | input | N_THR | Active threads, one bit each |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | TW | Allocating thread |
| alloc_seq | input | SEQ_W | Sequence number of new entry |
| alloc_tag | input | TAG_W | Tag stored with the entry |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tid | input | TW | Thread of completed entry |
| cmpl_seq | input | SEQ_W | Sequence number of completed entry |
| retire_req | input | N_THR | Per-thread retire strobe |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TW | Thread to squash |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| head_valid | output | N_THR | Thread holds at least one entry |
| head_ready | output | N_THR | Thread head may commit |
| head_seq | output | N_THR*SEQ_W | Head sequence number per thread |
| head_tag | output | N_THR*TAG_W | Head tag per thread |
| can_commit | output | 1 | Some active thread may commit |
| thread_state | output | 2*N_THR | 0 idle, 1 running, 2 squashing |
| sq_done | output | N_THR | Thread not squashing |
| all_sq_done | output | 1 | No thread squashing |
| free_total | output | CW | Free entries in the buffer |
| free_thread | output | N_THR*CW | Allowance left per thread |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| alloc_err | output | 1 | Previous-cycle allocation dropped |

## Verification
Allocation, completion, retire, the drop flag and allowance changes all take effect on the first edge after the request. The bench therefore drives each request, waits one edge and samples 2 ns after it. A squash is sampled after each edge of its walk. `sq_done` must stay low, and the counts must hold, up to the edge computed from R5. On that edge the counts must fall by K.

// File: rtl/rob_mt_pkg.sv
package rob_mt_pkg;
  typedef enum logic [1:0] {
    SHARE_DYN    = 2'd0,
    SHARE_PART   = 2'd1,
    SHARE_THRESH = 2'd2
  } share_e;

  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_RUN    = 2'd1,
    TS_SQUASH = 2'd2
  } tstate_e;
endpackage

// File: rtl/rob_mt_limit.sv
module rob_mt_limit
  import rob_mt_pkg::*;
#(
  parameter int     N_ENT      = 8,
  parameter int     N_THR      = 2,
  parameter share_e POLICY     = SHARE_PART,
  parameter int     THRESH_PCT = 50,
  localparam int    CW         = $clog2(N_ENT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_THR-1:0]    active_mask,
  output logic [N_THR*CW-1:0] cap_flat
);
  localparam int THR_CAP = (N_ENT * THRESH_PCT) / 100;
  localparam int AW      = $clog2(N_THR + 1);

  logic [AW-1:0] n_act;
  logic [CW-1:0] share;
  logic [CW-1:0] cap_q [N_THR];

  always_comb begin
    n_act = AW'($countones(active_mask));
    share = '0;
    case (POLICY)
      SHARE_DYN:    share = CW'(N_ENT);
      SHARE_THRESH: share = CW'(THR_CAP);
      default: begin
        for (int n = 1; n <= N_THR; n++)
          if (n_act == AW'(n)) share = CW'(N_ENT / n);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < N_THR; t++) begin
      if (rst) cap_q[t] <= '0;
      else     cap_q[t] <= active_mask[t] ? share : '0;
    end
  end

  for (genvar t = 0; t < N_THR; t++) begin : g_out
    assign cap_flat[t*CW +: CW] = cap_q[t];
  end
endmodule

// File: rtl/rob_mt_ring.sv
module rob_mt_ring
  import rob_mt_pkg::*;
#(
  parameter int  DEPTH = 8,
  parameter int  SEQ_W = 8,
  parameter int  TAG_W = 4,
  parameter int  SQW   = 2,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             cmpl_en,
  input  logic [SEQ_W-1:0] cmpl_seq,
  input  logic             retire_en,
  input  logic             squash_en,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [CW-1:0]    cap,
  output logic [CW-1:0]    cnt,
  output logic             room,
  output logic             head_valid,
  output logic             head_ready,
  output logic [SEQ_W-1:0] head_seq,
  output logic [TAG_W-1:0] head_tag,
  output logic [1:0]       state,
  output logic             sq_done
);
  // Storage written only at allocation, so it maps onto RAM
  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];

  logic [DEPTH-1:0] rdy_q, sqd_q, live, mark, cmpl_hit;
  logic [PW-1:0]    head_q, tail_q, walk_q;
  logic [CW-1:0]    cnt_q, left_q, nsq_q, step;
  logic [SEQ_W-1:0] sq_seq_q;
  logic             busy_q, stop, walk_fin, head_ok, do_ret;

  function automatic logic is_younger(input logic [SEQ_W-1:0] s,
                                      input logic [SEQ_W-1:0] ref_s);
    logic [SEQ_W-1:0] d;
    d = s - ref_s;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i]     = CW'(PW'(PW'(i) - head_q)) < cnt_q;
      cmpl_hit[i] = cmpl_en && live[i] && !sqd_q[i] && (seq_mem[i] == cmpl_seq);
    end
  end

  // Backward walk: up to SQW entries per cycle, stops at first older entry
  always_comb begin
    mark = '0;
    step = '0;
    stop = 1'b0;
    for (int k = 0; k < SQW; k++) begin
      if (!stop && (CW'(k) < left_q) &&
          is_younger(seq_mem[walk_q - PW'(k)], sq_seq_q)) begin
        mark[walk_q - PW'(k)] = 1'b1;
        step = step + CW'(1);
      end else begin
        stop = 1'b1;
      end
    end
    walk_fin = stop || (left_q == step);
  end

  assign head_ok = (cnt_q != '0) && rdy_q[head_q] && !sqd_q[head_q];
  assign do_ret  = retire_en && head_ok && !busy_q && !squash_en;

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      seq_mem[tail_q] <= alloc_seq;
      tag_mem[tail_q] <= alloc_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      tail_q   <= '0;
      walk_q   <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      nsq_q    <= '0;
      sq_seq_q <= '0;
      busy_q   <= 1'b0;
      rdy_q    <= '0;
      sqd_q    <= '0;
    end else begin
      rdy_q <= rdy_q | cmpl_hit;
      if (busy_q) begin
        sqd_q  <= sqd_q | mark;
        walk_q <= walk_q - PW'(step);
        left_q <= left_q - step;
        if (walk_fin) begin
          busy_q <= 1'b0;
          nsq_q  <= '0;
          cnt_q  <= cnt_q - (nsq_q + step);
          tail_q <= tail_q - PW'(nsq_q + step);
        end else begin
          nsq_q <= nsq_q + step;
        end
      end else if (squash_en) begin
        busy_q   <= 1'b1;
        sq_seq_q <= squash_seq;
        walk_q   <= tail_q - PW'(1);
        left_q   <= cnt_q;
        nsq_q    <= '0;
      end else begin
        if (alloc_en) begin
          tail_q         <= tail_q + PW'(1);
          rdy_q[tail_q]  <= 1'b0;
          sqd_q[tail_q]  <= 1'b0;
        end
        if (do_ret) head_q <= head_q + PW'(1);
        cnt_q <= cnt_q + CW'(alloc_en) - CW'(do_ret);
      end
    end
  end

  assign cnt        = cnt_q;
  assign room       = !busy_q && (cnt_q < cap);
  assign head_valid = cnt_q != '0;
  assign head_ready = head_ok && !busy_q;
  assign head_seq   = seq_mem[head_q];
  assign head_tag   = tag_mem[head_q];
  assign sq_done    = !busy_q;
  assign state      = busy_q ? TS_SQUASH : ((cnt_q == '0) ? TS_IDLE : TS_RUN);
endmodule

// File: rtl/rob_mt.sv
module rob_mt
  import rob_mt_pkg::*;
#(
  parameter int     N_ENT      = 8,
  parameter int     N_THR      = 2,
  parameter int     SEQ_W      = 8,
  parameter int     TAG_W      = 4,
  parameter int     SQ_W       = 2,
  parameter share_e POLICY     = SHARE_PART,
  parameter int     THRESH_PCT = 50,
  localparam int    CW         = $clog2(N_ENT + 1),
  localparam int    TW         = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_THR-1:0]       active_mask,
  input  logic                   alloc_valid,
  input  logic [TW-1:0]          alloc_tid,
  input  logic [SEQ_W-1:0]       alloc_seq,
  input  logic [TAG_W-1:0]       alloc_tag,
  input  logic                   cmpl_valid,
  input  logic [TW-1:0]          cmpl_tid,
  input  logic [SEQ_W-1:0]       cmpl_seq,
  input  logic [N_THR-1:0]       retire_req,
  input  logic                   squash_valid,
  input  logic [TW-1:0]          squash_tid,
  input  logic [SEQ_W-1:0]       squash_seq,
  output logic [N_THR-1:0]       head_valid,
  output logic [N_THR-1:0]       head_ready,
  output logic [N_THR*SEQ_W-1:0] head_seq,
  output logic [N_THR*TAG_W-1:0] head_tag,
  output logic                   can_commit,
  output logic [2*N_THR-1:0]     thread_state,
  output logic [N_THR-1:0]       sq_done,
  output logic                   all_sq_done,
  output logic [CW-1:0]          free_total,
  output logic [N_THR*CW-1:0]    free_thread,
  output logic                   full,
  output logic                   empty,
  output logic                   alloc_err
);
  logic [N_THR*CW-1:0] cap_flat;
  logic [CW-1:0]       cnt_a [N_THR];
  logic [N_THR-1:0]    room, alloc_go;
  logic [CW-1:0]       total;

  rob_mt_limit #(
    .N_ENT(N_ENT), .N_THR(N_THR), .POLICY(POLICY), .THRESH_PCT(THRESH_PCT)
  ) u_limit (
    .clk(clk), .rst(rst), .active_mask(active_mask), .cap_flat(cap_flat)
  );

  always_comb begin
    total = '0;
    for (int t = 0; t < N_THR; t++) total = total + cnt_a[t];
  end

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic sq_hit;
    assign sq_hit      = squash_valid && (squash_tid == TW'(t));
    assign alloc_go[t] = alloc_valid && (alloc_tid == TW'(t)) && room[t] &&
                         (total < CW'(N_ENT)) && !sq_hit;

    rob_mt_ring #(
      .DEPTH(N_ENT), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .SQW(SQ_W)
    ) u_ring (
      .clk       (clk),
      .rst       (rst),
      .alloc_en  (alloc_go[t]),
      .alloc_seq (alloc_seq),
      .alloc_tag (alloc_tag),
      .cmpl_en   (cmpl_valid && (cmpl_tid == TW'(t))),
      .cmpl_seq  (cmpl_seq),
      .retire_en (retire_req[t]),
      .squash_en (sq_hit),
      .squash_seq(squash_seq),
      .cap       (cap_flat[t*CW +: CW]),
      .cnt       (cnt_a[t]),
      .room      (room[t]),
      .head_valid(head_valid[t]),
      .head_ready(head_ready[t]),
      .head_seq  (head_seq[t*SEQ_W +: SEQ_W]),
      .head_tag  (head_tag[t*TAG_W +: TAG_W]),
      .state     (thread_state[2*t +: 2]),
      .sq_done   (sq_done[t])
    );

    assign free_thread[t*CW +: CW] = (cap_flat[t*CW +: CW] > cnt_a[t]) ?
                                     (cap_flat[t*CW +: CW] - cnt_a[t]) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) alloc_err <= 1'b0;
    else     alloc_err <= alloc_valid && (alloc_go == '0);
  end

  assign can_commit  = |(head_ready & active_mask);
  assign all_sq_done = &sq_done;
  assign free_total  = CW'(N_ENT) - total;
  assign full        = (total == CW'(N_ENT));
  assign empty       = (total == '0);
endmodule

// File: rtl/rob_mt_chk.sv
module rob_mt_chk #(
  parameter int  N_ENT = 8,
  parameter int  N_THR = 2,
  localparam int CW    = $clog2(N_ENT + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [N_THR-1:0]    active_mask,
  input logic                alloc_valid,
  input logic                full,
  input logic                empty,
  input logic [CW-1:0]       free_total,
  input logic [N_THR*CW-1:0] free_thread,
  input logic [N_THR-1:0]    head_valid,
  input logic [N_THR-1:0]    head_ready,
  input logic [2*N_THR-1:0]  thread_state,
  input logic                alloc_err
);
  a_r10_full_no_free: assert property (@(posedge clk) disable iff (rst)
    full |-> (free_total == '0));

  a_r10_empty_no_head: assert property (@(posedge clk) disable iff (rst)
    empty |-> (head_valid == '0));

  a_r9_full_drops: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && full) |=> alloc_err);

  for (genvar t = 0; t < N_THR; t++) begin : g_t
    a_r7_no_commit_squash: assert property (@(posedge clk) disable iff (rst)
      (thread_state[2*t +: 2] == 2'd2) |-> !head_ready[t]);

    a_r3_ready_needs_head: assert property (@(posedge clk) disable iff (rst)
      head_ready[t] |-> head_valid[t]);

    // R6: a walk leaves the thread's occupancy untouched
    a_r6_walk_holds_count: assert property (@(posedge clk) disable iff (rst)
      ((thread_state[2*t +: 2] == 2'd2) && ($past(thread_state[2*t +: 2]) == 2'd2) &&
       (active_mask == $past(active_mask)) && ($past(active_mask) == $past(active_mask, 2)))
      |-> (free_thread[t*CW +: CW] == $past(free_thread[t*CW +: CW])));
  end
endmodule

bind rob_mt rob_mt_chk #(.N_ENT(N_ENT), .N_THR(N_THR)) u_chk (.*);

// File: tb/rob_mt_tb.sv
module rob_mt_tb;
  localparam logic [1:0] OP_ALLOC = 2'd0;
  localparam logic [1:0] OP_CMPL  = 2'd1;
  localparam logic [1:0] OP_RET   = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic       tid;
    logic [7:0] seq;
    logic [3:0] efree;
    logic       ev;
    logic [7:0] ehead;
    logic       erdy;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{OP_ALLOC, 1'b0, 8'd10, 4'd7, 1'b1, 8'd10, 1'b0},
    '{OP_ALLOC, 1'b0, 8'd11, 4'd6, 1'b1, 8'd10, 1'b0},
    '{OP_ALLOC, 1'b1, 8'd50, 4'd5, 1'b1, 8'd50, 1'b0},
    '{OP_CMPL,  1'b0, 8'd11, 4'd5, 1'b1, 8'd10, 1'b0},
    '{OP_RET,   1'b0, 8'd0,  4'd5, 1'b1, 8'd10, 1'b0},
    '{OP_CMPL,  1'b0, 8'd10, 4'd5, 1'b1, 8'd10, 1'b1},
    '{OP_RET,   1'b0, 8'd0,  4'd6, 1'b1, 8'd11, 1'b1},
    '{OP_RET,   1'b0, 8'd0,  4'd7, 1'b0, 8'd0,  1'b0},
    '{OP_CMPL,  1'b1, 8'd50, 4'd7, 1'b1, 8'd50, 1'b1},
    '{OP_RET,   1'b1, 8'd0,  4'd8, 1'b0, 8'd0,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] active_mask = 2'b11;
  logic       alloc_valid = 1'b0, alloc_tid = 1'b0;
  logic [7:0] alloc_seq = '0;
  logic [3:0] alloc_tag = '0;
  logic       cmpl_valid = 1'b0, cmpl_tid = 1'b0;
  logic [7:0] cmpl_seq = '0;
  logic [1:0] retire_req = '0;
  logic       squash_valid = 1'b0, squash_tid = 1'b0;
  logic [7:0] squash_seq = '0;

  logic [1:0]  head_valid, head_ready, sq_done;
  logic [15:0] head_seq;
  logic [7:0]  head_tag;
  logic        can_commit, all_sq_done, full, empty, alloc_err;
  logic [3:0]  thread_state;
  logic [3:0]  free_total;
  logic [7:0]  free_thread;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rob_mt u_dut (
    .clk(clk), .rst(rst), .active_mask(active_mask),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tid(cmpl_tid), .cmpl_seq(cmpl_seq),
    .retire_req(retire_req),
    .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
    .head_valid(head_valid), .head_ready(head_ready), .head_seq(head_seq), .head_tag(head_tag),
    .can_commit(can_commit), .thread_state(thread_state), .sq_done(sq_done),
    .all_sq_done(all_sq_done), .free_total(free_total), .free_thread(free_thread),
    .full(full), .empty(empty), .alloc_err(alloc_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    alloc_valid  = 1'b0;
    cmpl_valid   = 1'b0;
    retire_req   = '0;
    squash_valid = 1'b0;
  endtask

  task automatic do_alloc(input logic t, input logic [7:0] s);
    alloc_valid = 1'b1; alloc_tid = t; alloc_seq = s; alloc_tag = s[3:0];
    tick();
    quiet();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    quiet();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    do_reset();
    // R1 reset state, R8 allowance with both threads active
    chk("R1", "free_total", free_total, 8);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "head_valid", head_valid, 0);
    chk("R1", "sq_done", sq_done, 3);
    chk("R1", "all_sq_done", all_sq_done, 1);
    chk("R1", "thread_state", thread_state, 0);
    chk("R1", "alloc_err", alloc_err, 0);
    chk("R1", "can_commit", can_commit, 0);
    chk("R8", "free_thread0", free_thread[3:0], 4);
    chk("R8", "free_thread1", free_thread[7:4], 4);

    // Vector table: R2 allocate, R3 complete, R4 retire
    for (int i = 0; i < NV; i++) begin
      string rq;
      case (VEC[i].op)
        OP_ALLOC: begin
          rq = "R2";
          alloc_valid = 1'b1; alloc_tid = VEC[i].tid;
          alloc_seq = VEC[i].seq; alloc_tag = VEC[i].seq[3:0];
        end
        OP_CMPL: begin
          rq = "R3";
          cmpl_valid = 1'b1; cmpl_tid = VEC[i].tid; cmpl_seq = VEC[i].seq;
        end
        default: begin
          rq = "R4";
          retire_req[VEC[i].tid] = 1'b1;
        end
      endcase
      tick();
      quiet();
      chk("R10", "free_total", free_total, VEC[i].efree);
      chk(rq, "head_valid", head_valid[VEC[i].tid], VEC[i].ev);
      if (VEC[i].ev) chk(rq, "head_seq", head_seq[VEC[i].tid*8 +: 8], VEC[i].ehead);
      chk(rq, "head_ready", head_ready[VEC[i].tid], VEC[i].erdy);
      chk("R3", "can_commit", can_commit, VEC[i].erdy);
    end

    // R8: only thread 0 active -> it gets all 8, thread 1 gets 0
    active_mask = 2'b01;
    tick();
    chk("R8", "free_thread0 single", free_thread[3:0], 8);
    chk("R8", "free_thread1 inactive", free_thread[7:4], 0);
    do_alloc(1'b1, 8'd90);
    chk("R8", "alloc_err inactive", alloc_err, 1);
    chk("R8", "free_total inactive", free_total, 8);
    active_mask = 2'b11;
    tick();
    chk("R8", "free_thread0 restored", free_thread[3:0], 4);

    // R9: thread 0 at its allowance
    for (int s = 20; s < 24; s++) do_alloc(1'b0, 8'(s));
    chk("R9", "alloc_err accepted", alloc_err, 0);
    chk("R9", "free_thread0 zero", free_thread[3:0], 0);
    do_alloc(1'b0, 8'd24);
    chk("R9", "alloc_err over limit", alloc_err, 1);
    chk("R9", "free_total unchanged", free_total, 4);
    for (int s = 30; s < 34; s++) do_alloc(1'b1, 8'(s));
    chk("R10", "full", full, 1);
    chk("R10", "empty", empty, 0);
    chk("R10", "free_total full", free_total, 0);
    do_alloc(1'b1, 8'd34);
    chk("R9", "alloc_err full", alloc_err, 1);

    // R5/R6/R7: squash thread 0 younger than 20 (3 younger, width 2)
    squash_valid = 1'b1; squash_tid = 1'b0; squash_seq = 8'd20;
    tick();
    quiet();
    chk("R5", "state squashing", thread_state[1:0], 2);
    chk("R5", "sq_done0 low", sq_done[0], 0);
    chk("R5", "all_sq_done low", all_sq_done, 0);
    alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_seq = 8'd40;
    cmpl_valid = 1'b1; cmpl_tid = 1'b1; cmpl_seq = 8'd30;
    tick();
    quiet();
    chk("R7", "alloc_err while squashing", alloc_err, 1);
    chk("R7", "head_ready0 low", head_ready[0], 0);
    chk("R7", "head_ready1 other thread", head_ready[1], 1);
    chk("R7", "can_commit other thread", can_commit, 1);
    chk("R6", "free_total held", free_total, 0);
    chk("R5", "sq_done0 mid walk", sq_done[0], 0);
    tick();
    chk("R5", "sq_done0 finished", sq_done[0], 1);
    chk("R5", "all_sq_done", all_sq_done, 1);
    chk("R6", "free_total after", free_total, 3);
    chk("R6", "free_thread0 after", free_thread[3:0], 3);
    chk("R6", "head_seq0 survivor", head_seq[7:0], 20);
    chk("R5", "state running", thread_state[1:0], 1);

    // R11: wrap-safe compare across 255 -> 0
    do_reset();
    do_alloc(1'b0, 8'd254);
    do_alloc(1'b0, 8'd255);
    do_alloc(1'b0, 8'd0);
    do_alloc(1'b0, 8'd1);
    squash_valid = 1'b1; squash_tid = 1'b0; squash_seq = 8'd255;
    tick();
    quiet();
    tick();
    chk("R11", "sq_done0 mid", sq_done[0], 0);
    tick();
    chk("R11", "sq_done0 done", sq_done[0], 1);
    chk("R11", "free_thread0 wrapped", free_thread[3:0], 2);
    chk("R11", "head_seq0", head_seq[7:0], 254);
    chk("R11", "free_total", free_total, 6);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule